// File: doc/BRIEF.md
# ADPCM Sample Streaming Accelerator

The block turns a stream of packed audio data held in byte-addressed memory into one signed 16-bit sample for each read request. A format register chooses among three encodings: 4-bit adaptive differential PCM, big-endian 16-bit PCM and 8-bit PCM. In the ADPCM case the block runs a two-tap predictor. It takes the taps from a 16-entry coefficient table, scales the nibble by a power of two, and keeps the last two outputs as history. Every sixteen nibbles it fetches a new predictor/scale header byte from memory.

A controller sets up the stream through 16-bit registers. These hold the loop start, end and current addresses, each split into high and low halves, plus the format, the two history values and the predictor/scale byte. It then pulses the read strobe once for each sample it wants. A small sequencer fetches the one or two bytes the sample needs over a request/acknowledge memory port and returns the sample with a one-cycle done pulse.

When the stream runs past its end address, the current address falls back to the loop start, an exception pulse goes out with that sample, and an internal stop flag freezes the stream. The flag stays set until the second history register is written. Two end-address alignments follow special wrap rules that neither raise the exception nor fetch a header.

Top module: `sample_stream_accel`

## Requirements
- R1: After reset every register reads zero (index 0 start high, 1 start low, 2 end high, 3 end low, 4 current high, 5 current low, 6 format, 7 history 1, 8 history 2, 9 predictor/scale), the stop flag is clear and `busy`, `rd_done` and `end_exc` are low.
- R2: Start and end addresses are stored ANDed with 0x3FFFFFFF, the current address with 0xBFFFFFFF and the predictor/scale value with 0x7F. The format and history registers keep all 16 bits. Each address is accessed as a high half and a low half.
- R3: Format 0x0A returns `{mem[2a], mem[2a+1]}` and format 0x19 returns `{mem[a], 8'h00}`. Format 0x00 is ADPCM. Any other code returns 0 and leaves the history unchanged. In every format except ADPCM the address advances by 1.
- R4: In ADPCM mode the address counts nibbles. The data byte is `mem[a>>1]`. An odd address takes bits [3:0] and an even address takes bits [7:4], and the nibble is sign-extended.
- R5: An ADPCM sample equals `(nibble << ps[3:0]) + ((1024 + C[2k]*h1 + C[2k+1]*h2) >>> 11)` with `k = ps[6:4]`, computed without overflow and saturated to -32767..32767.
- R6: Every decoded sample in formats 0x00, 0x0A and 0x19 moves history 1 into history 2 and becomes the new history 1.
- R7: After the ADPCM increment, if the address has low nibble 0 and no end special case applies, the predictor/scale register loads `mem[(a & ~15) >> 1]` unmasked and the address advances by a further 2.
- R8: If the end address has low nibble 0 and the incremented address equals the end, the address becomes start+1. If the end address has low nibble 1 and the incremented address equals end-1, the address becomes start. These two checks take priority over the header fetch.
- R9: After the step, if the address equals end+1 (end+3 when a header was fetched), the address becomes start, the stop flag is set and `end_exc` pulses.
- R10: While the stop flag is set, a read returns 0 without changing the address, history or predictor. Writing history 2 clears the flag.
- R11: `rd_done` lasts exactly one cycle for each request, and `end_exc` is high only in the same cycle as `rd_done`.
- R12: Register writes are ignored while `busy` is high.
- R13: `mem_req` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| rd_req | input | 1 | Sample request strobe, one cycle |
| rd_done | output | 1 | Sample valid pulse |
| rd_data | output | 16 | Returned sample |
| coef_flat | input | NCOEF*CW | Signed coefficient table, entry i at bits [i*CW +: CW] |
| mem_req | output | 1 | Memory byte request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 8 | Memory byte |
| end_exc | output | 1 | End-of-stream exception pulse |
| busy | output | 1 | Sequencer active |

## Verification
The assertions assume that `rd_req` arrives only while `busy` is low, that `mem_ack` is high for at most one cycle and only while `mem_req` is high, and that the coefficient table does not change during a request. The bench meets these by issuing each request only after the previous done pulse, by answering memory from a responder that acknowledges once per pending request after a set latency, and by loading the coefficients once at start. The bench also never writes a register in the same cycle as a request, because that would make the order of the write and the read ambiguous.

// File: rtl/accel_pkg.sv
package accel_pkg;
  localparam int ADDR_W = 32;
  localparam int SMP_W  = 16;
  localparam int ACC_W  = 36;

  localparam logic [15:0] FMT_ADPCM = 16'h0000;
  localparam logic [15:0] FMT_PCM16 = 16'h000A;
  localparam logic [15:0] FMT_PCM8  = 16'h0019;

  localparam logic [ADDR_W-1:0] LOOP_MASK = 32'h3FFF_FFFF;
  localparam logic [ADDR_W-1:0] CUR_MASK  = 32'hBFFF_FFFF;
  localparam logic [7:0]        PS_MASK   = 8'h7F;

  localparam logic [3:0] RI_START_HI = 4'd0;
  localparam logic [3:0] RI_START_LO = 4'd1;
  localparam logic [3:0] RI_END_HI   = 4'd2;
  localparam logic [3:0] RI_END_LO   = 4'd3;
  localparam logic [3:0] RI_CUR_HI   = 4'd4;
  localparam logic [3:0] RI_CUR_LO   = 4'd5;
  localparam logic [3:0] RI_FMT      = 4'd6;
  localparam logic [3:0] RI_HIST1    = 4'd7;
  localparam logic [3:0] RI_HIST2    = 4'd8;
  localparam logic [3:0] RI_PSCALE   = 4'd9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA0,
    ST_DATA1,
    ST_HDR,
    ST_DONE
  } accel_state_t;

  function automatic logic signed [SMP_W-1:0] sat_sample(input logic signed [ACC_W-1:0] v);
    if (v > 36'sd32767)       return 16'sh7FFF;
    else if (v < -36'sd32767) return 16'sh8001;
    else                      return v[SMP_W-1:0];
  endfunction

  function automatic logic signed [3:0] pick_nibble(input logic [7:0] b, input logic odd);
    return odd ? b[3:0] : b[7:4];
  endfunction
endpackage

// File: rtl/accel_adpcm_calc.sv
module accel_adpcm_calc
  import accel_pkg::*;
#(
  parameter int NCOEF = 16,
  parameter int CW    = 16
) (
  input  logic [7:0]             data_byte,
  input  logic                   nib_odd,
  input  logic [6:0]             pscale,
  input  logic [NCOEF*CW-1:0]    coef_flat,
  input  logic signed [SMP_W-1:0] hist1,
  input  logic signed [SMP_W-1:0] hist2,
  output logic signed [SMP_W-1:0] sample
);
  localparam int IDX_W = $clog2(NCOEF);

  logic signed [CW-1:0] ctab [NCOEF];

  for (genvar i = 0; i < NCOEF; i++) begin : g_ctab
    assign ctab[i] = coef_flat[i*CW +: CW];
  end

  logic [IDX_W-1:0]         idx_a;
  logic [IDX_W-1:0]         idx_b;
  logic signed [3:0]        nib;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [ACC_W-1:0]  c1_w, c2_w, h1_w, h2_w;
  logic signed [ACC_W-1:0]  pred;
  logic signed [ACC_W-1:0]  total;

  always_comb begin
    idx_a  = IDX_W'({pscale[6:4], 1'b0});
    idx_b  = IDX_W'({pscale[6:4], 1'b1});
    nib    = pick_nibble(data_byte, nib_odd);
    scaled = ACC_W'(nib) <<< pscale[3:0];
    c1_w   = ACC_W'(ctab[idx_a]);
    c2_w   = ACC_W'(ctab[idx_b]);
    h1_w   = ACC_W'(hist1);
    h2_w   = ACC_W'(hist2);
    pred   = 36'sd1024 + c1_w * h1_w + c2_w * h2_w;
    total  = scaled + (pred >>> 11);
    sample = sat_sample(total);
  end
endmodule

// File: rtl/accel_addr_next.sv
module accel_addr_next
  import accel_pkg::*;
(
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] end_a,
  output logic [ADDR_W-1:0] next_a,
  output logic              hdr_need
);
  logic [ADDR_W-1:0] inc_a;

  always_comb begin
    inc_a    = cur + 32'd1;
    next_a   = inc_a;
    hdr_need = 1'b0;
    if (end_a[3:0] == 4'h0 && inc_a == end_a) begin
      next_a = start_a + 32'd1;
    end else if (end_a[3:0] == 4'h1 && inc_a == end_a - 32'd1) begin
      next_a = start_a;
    end else if (inc_a[3:0] == 4'h0) begin
      hdr_need = 1'b1;
    end
  end
endmodule

// File: rtl/accel_end_check.sv
module accel_end_check
  import accel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              long_step,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] end_a,
  output logic [ADDR_W-1:0] addr_out,
  output logic              end_hit
);
  logic [ADDR_W-1:0] limit;

  always_comb begin
    limit    = end_a + (long_step ? 32'd3 : 32'd1);
    end_hit  = (addr_in == limit);
    addr_out = (end_hit ? start_a : addr_in) & CUR_MASK;
  end
endmodule

// File: rtl/sample_stream_accel.sv
module sample_stream_accel
  import accel_pkg::*;
#(
  parameter int NCOEF = 16,
  parameter int CW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [3:0]            reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  input  logic                  rd_req,
  output logic                  rd_done,
  output logic [15:0]           rd_data,
  input  logic [NCOEF*CW-1:0]   coef_flat,
  output logic                  mem_req,
  output logic [31:0]           mem_addr,
  input  logic                  mem_ack,
  input  logic [7:0]            mem_rdata,
  output logic                  end_exc,
  output logic                  busy
);
  accel_state_t state;

  logic [ADDR_W-1:0]        start_q, end_q, cur_q;
  logic [15:0]              fmt_q;
  logic signed [SMP_W-1:0]  hist1_q, hist2_q;
  logic [7:0]               ps_q;
  logic                     stopped_q;
  logic [SMP_W-1:0]         sample_q;
  logic [7:0]               hi_q;
  logic                     exc_q;

  logic is_adpcm, is_pcm16, is_pcm8, is_known;
  assign is_adpcm = (fmt_q == FMT_ADPCM);
  assign is_pcm16 = (fmt_q == FMT_PCM16);
  assign is_pcm8  = (fmt_q == FMT_PCM8);
  assign is_known = is_adpcm | is_pcm16 | is_pcm8;

  // ADPCM arithmetic
  logic signed [SMP_W-1:0] adp_sample;
  accel_adpcm_calc #(.NCOEF(NCOEF), .CW(CW)) u_calc (
    .data_byte (mem_rdata),
    .nib_odd   (cur_q[0]),
    .pscale    (ps_q[6:0]),
    .coef_flat (coef_flat),
    .hist1     (hist1_q),
    .hist2     (hist2_q),
    .sample    (adp_sample)
  );

  // ADPCM address progression
  logic [ADDR_W-1:0] adp_next;
  logic              hdr_need;
  accel_addr_next u_next (
    .cur      (cur_q),
    .start_a  (start_q),
    .end_a    (end_q),
    .next_a   (adp_next),
    .hdr_need (hdr_need)
  );

  // Final step address and end detection
  logic [ADDR_W-1:0] fin_in, fin_out;
  logic              fin_long, fin_hit;

  always_comb begin
    fin_long = (state == ST_HDR);
    if (state == ST_HDR)                      fin_in = cur_q + 32'd2;
    else if (state == ST_DATA0 && is_adpcm)   fin_in = adp_next;
    else                                      fin_in = cur_q + 32'd1;
  end

  accel_end_check u_end (
    .addr_in   (fin_in),
    .long_step (fin_long),
    .start_a   (start_q),
    .end_a     (end_q),
    .addr_out  (fin_out),
    .end_hit   (fin_hit)
  );

  // Named internal events
  logic wr_ok;
  logic step_commit;
  logic hdr_fetch;
  assign wr_ok     = reg_we && (state == ST_IDLE);
  assign hdr_fetch = (state == ST_DATA0) && mem_ack && is_adpcm && hdr_need;
  always_comb begin
    step_commit = 1'b0;
    case (state)
      ST_IDLE:  step_commit = rd_req && !stopped_q && !is_known;
      ST_DATA0: step_commit = mem_ack && (is_pcm8 || (is_adpcm && !hdr_need));
      ST_DATA1: step_commit = mem_ack;
      ST_HDR:   step_commit = mem_ack;
      default:  step_commit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      start_q   <= '0;
      end_q     <= '0;
      cur_q     <= '0;
      fmt_q     <= '0;
      hist1_q   <= '0;
      hist2_q   <= '0;
      ps_q      <= '0;
      stopped_q <= 1'b0;
      sample_q  <= '0;
      hi_q      <= '0;
      exc_q     <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          RI_START_HI: start_q <= {reg_wdata, start_q[15:0]} & LOOP_MASK;
          RI_START_LO: start_q <= {start_q[31:16], reg_wdata} & LOOP_MASK;
          RI_END_HI:   end_q   <= {reg_wdata, end_q[15:0]} & LOOP_MASK;
          RI_END_LO:   end_q   <= {end_q[31:16], reg_wdata} & LOOP_MASK;
          RI_CUR_HI:   cur_q   <= {reg_wdata, cur_q[15:0]} & CUR_MASK;
          RI_CUR_LO:   cur_q   <= {cur_q[31:16], reg_wdata} & CUR_MASK;
          RI_FMT:      fmt_q   <= reg_wdata;
          RI_HIST1:    hist1_q <= reg_wdata;
          RI_HIST2: begin
            hist2_q   <= reg_wdata;
            stopped_q <= 1'b0;
          end
          RI_PSCALE:   ps_q    <= reg_wdata[7:0] & PS_MASK;
          default: ;
        endcase
      end

      case (state)
        ST_IDLE: begin
          if (rd_req) begin
            if (stopped_q) begin
              sample_q <= '0;
              exc_q    <= 1'b0;
              state    <= ST_DONE;
            end else if (is_known) begin
              state <= ST_DATA0;
            end else begin
              sample_q <= '0;
              state    <= ST_DONE;
            end
          end
        end
        ST_DATA0: begin
          if (mem_ack) begin
            if (is_adpcm) begin
              sample_q <= adp_sample;
              hist1_q  <= adp_sample;
              hist2_q  <= hist1_q;
              if (hdr_need) begin
                cur_q <= adp_next;
                state <= ST_HDR;
              end else begin
                state <= ST_DONE;
              end
            end else if (is_pcm16) begin
              hi_q  <= mem_rdata;
              state <= ST_DATA1;
            end else begin
              sample_q <= {mem_rdata, 8'h00};
              hist1_q  <= {mem_rdata, 8'h00};
              hist2_q  <= hist1_q;
              state    <= ST_DONE;
            end
          end
        end
        ST_DATA1: begin
          if (mem_ack) begin
            sample_q <= {hi_q, mem_rdata};
            hist1_q  <= {hi_q, mem_rdata};
            hist2_q  <= hist1_q;
            state    <= ST_DONE;
          end
        end
        ST_HDR: begin
          if (mem_ack) begin
            ps_q  <= mem_rdata;
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          exc_q <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase

      if (step_commit) begin
        cur_q <= fin_out;
        exc_q <= fin_hit;
        if (fin_hit) stopped_q <= 1'b1;
      end
    end
  end

  // Memory port
  always_comb begin
    mem_req  = 1'b0;
    mem_addr = '0;
    case (state)
      ST_DATA0: begin
        mem_req = 1'b1;
        if (is_adpcm)      mem_addr = {1'b0, cur_q[31:1]};
        else if (is_pcm16) mem_addr = {cur_q[30:0], 1'b0};
        else               mem_addr = cur_q;
      end
      ST_DATA1: begin
        mem_req  = 1'b1;
        mem_addr = {cur_q[30:0], 1'b1};
      end
      ST_HDR: begin
        mem_req  = 1'b1;
        mem_addr = {1'b0, cur_q[31:4], 3'b000};
      end
      default: ;
    endcase
  end

  // Register readback
  always_comb begin
    case (reg_addr)
      RI_START_HI: reg_rdata = start_q[31:16];
      RI_START_LO: reg_rdata = start_q[15:0];
      RI_END_HI:   reg_rdata = end_q[31:16];
      RI_END_LO:   reg_rdata = end_q[15:0];
      RI_CUR_HI:   reg_rdata = cur_q[31:16];
      RI_CUR_LO:   reg_rdata = cur_q[15:0];
      RI_FMT:      reg_rdata = fmt_q;
      RI_HIST1:    reg_rdata = hist1_q;
      RI_HIST2:    reg_rdata = hist2_q;
      RI_PSCALE:   reg_rdata = {8'h00, ps_q};
      default:     reg_rdata = '0;
    endcase
  end

  assign rd_done = (state == ST_DONE);
  assign rd_data = sample_q;
  assign end_exc = (state == ST_DONE) && exc_q;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/accel_chk.sv
module accel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        rd_done,
  input logic [15:0] rd_data,
  input logic        end_exc,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        busy,
  input logic        reg_we,
  input logic        stopped,
  input logic [31:0] start_addr
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R11

  AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    end_exc |-> rd_done); // R11

  AST_EXC_SETS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    end_exc |-> stopped); // R9

  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_req && stopped) |=> (rd_done && rd_data == 16'h0000 && !end_exc)); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R13

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> $stable(start_addr)); // R12
endmodule

bind sample_stream_accel accel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_done    (rd_done),
  .rd_data    (rd_data),
  .end_exc    (end_exc),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .reg_we     (reg_we),
  .stopped    (stopped_q),
  .start_addr (start_q)
);

// File: tb/sample_stream_accel_tb.sv
module sample_stream_accel_tb;
  localparam int NCOEF = 16;
  localparam int CW    = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                reg_we = 1'b0;
  logic [3:0]          reg_addr = '0;
  logic [15:0]         reg_wdata = '0;
  logic [15:0]         reg_rdata;
  logic                rd_req = 1'b0;
  logic                rd_done;
  logic [15:0]         rd_data;
  logic [NCOEF*CW-1:0] coef_flat = '0;
  logic                mem_req;
  logic [31:0]         mem_addr;
  logic                mem_ack = 1'b0;
  logic [7:0]          mem_rdata = '0;
  logic                end_exc;
  logic                busy;

  always #4 clk = ~clk;

  sample_stream_accel #(.NCOEF(NCOEF), .CW(CW)) u_dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .rd_req, .rd_done, .rd_data, .coef_flat,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata, .end_exc, .busy
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [256];
  int         coef [NCOEF];

  // memory responder with programmable latency and hold monitor
  int          lat = 0;
  int          wait_cnt = 0;
  int          hold_err = 0;
  logic [31:0] held_addr = '0;
  logic        pending = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
      pending  <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      pending <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_req) begin
      if (pending && mem_addr !== held_addr) hold_err <= hold_err + 1;
      if (!pending) held_addr <= mem_addr;
      pending <= 1'b1;
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // reference state
  logic [31:0] m_start, m_end, m_cur;
  logic [15:0] m_fmt;
  int          m_y1, m_y2;
  logic [7:0]  m_ps;
  logic        m_stop;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic configure(input logic [15:0] f, input logic [31:0] s, input logic [31:0] e,
                           input logic [31:0] c, input logic [7:0] p,
                           input logic [15:0] y1, input logic [15:0] y2);
    wr(4'd0, s[31:16]); wr(4'd1, s[15:0]);
    wr(4'd2, e[31:16]); wr(4'd3, e[15:0]);
    wr(4'd4, c[31:16]); wr(4'd5, c[15:0]);
    wr(4'd6, f); wr(4'd9, {8'h00, p}); wr(4'd7, y1); wr(4'd8, y2);
    m_start = s & 32'h3FFF_FFFF; m_end = e & 32'h3FFF_FFFF; m_cur = c & 32'hBFFF_FFFF;
    m_fmt = f; m_ps = p & 8'h7F; m_y1 = int'($signed(y1)); m_y2 = int'($signed(y2));
    m_stop = 1'b0;
  endtask

  // independent model of one read
  task automatic model_read(output logic [15:0] ev, output logic ex);
    logic [31:0] a;
    logic [7:0]  b;
    int          step, nib, k;
    longint      acc, pr;
    ex = 1'b0;
    if (m_stop) begin ev = 16'h0; return; end
    step = 2;
    a = m_cur + 1;
    if (m_fmt == 16'h0000) begin
      b = mem[8'(m_cur >> 1)];
      nib = (m_cur % 2 == 1) ? int'(b & 8'h0F) : int'(b / 16);
      if (nib >= 8) nib = nib - 16;
      k = int'(m_ps[6:4]);
      pr = 64'sd1024 + longint'(coef[2*k]) * m_y1 + longint'(coef[2*k+1]) * m_y2;
      acc = longint'(nib) * (longint'(1) << m_ps[3:0]) + (pr >>> 11);
      if (acc > 32767) acc = 32767;
      if (acc < -32767) acc = -32767;
      ev = acc[15:0];
      m_y2 = m_y1; m_y1 = int'(acc);
      if (m_end % 16 == 0 && a == m_end) a = m_start + 1;
      else if (m_end % 16 == 1 && a == m_end - 1) a = m_start;
      else if (a % 16 == 0) begin
        m_ps = mem[8'((a - (a % 16)) / 2)];
        a = a + 2; step = 4;
      end
    end else if (m_fmt == 16'h000A) begin
      ev = {mem[8'(m_cur * 2)], mem[8'(m_cur * 2 + 1)]};
      m_y2 = m_y1; m_y1 = int'($signed(ev));
    end else if (m_fmt == 16'h0019) begin
      ev = {mem[8'(m_cur)], 8'h00};
      m_y2 = m_y1; m_y1 = int'($signed(ev));
    end else begin
      ev = 16'h0;
    end
    if (a == m_end + step - 1) begin
      a = m_start; m_stop = 1'b1; ex = 1'b1;
    end
    m_cur = a & 32'hBFFF_FFFF;
  endtask

  task automatic do_read(output logic [15:0] d, output logic ex);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    while (!rd_done) @(negedge clk);
    d = rd_data; ex = end_exc;
    @(negedge clk);
    chk("R11 done pulse width", {31'd0, rd_done}, 32'd0);
  endtask

  task automatic read_and_compare();
    logic [15:0] d, ev, r;
    logic ex, eex, was_stop;
    string tag;
    was_stop = m_stop;
    model_read(ev, eex);
    do_read(d, ex);
    if (was_stop)                tag = "R10 stopped read";
    else if (m_fmt == 16'h0000)  tag = "R4/R5 adpcm sample";
    else                         tag = "R3 pcm sample";
    chk(tag, {16'd0, d}, {16'd0, ev});
    chk("R9 end exception", {31'd0, ex}, {31'd0, eex});
    rdreg(4'd5, r); chk("R7/R8/R9 current low", {16'd0, r}, {16'd0, m_cur[15:0]});
    rdreg(4'd4, r); chk("R7/R8/R9 current high", {16'd0, r}, {16'd0, m_cur[31:16]});
    rdreg(4'd7, r); chk("R6 history 1", {16'd0, r}, {16'd0, m_y1[15:0]});
    rdreg(4'd8, r); chk("R6 history 2", {16'd0, r}, {16'd0, m_y2[15:0]});
    rdreg(4'd9, r); chk("R7 predictor/scale", {16'd0, r}, {24'd0, m_ps});
  endtask

  typedef struct packed {
    logic [15:0] fmt;
    logic [31:0] st;
    logic [31:0] en;
    logic [31:0] cu;
    logic [7:0]  ps;
    logic [15:0] y1;
    logic [15:0] y2;
    logic [7:0]  n;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 32'h20, 32'h45, 32'h22, 8'h13, 16'h0064, 16'hFFCE, 8'd40},
    '{16'h0000, 32'h10, 32'h40, 32'h3C, 8'h25, 16'h0000, 16'h0000, 8'd8},
    '{16'h0000, 32'h30, 32'h51, 32'h4C, 8'h31, 16'h0200, 16'h0100, 8'd6},
    '{16'h000A, 32'h10, 32'h18, 32'h14, 8'h00, 16'h0000, 16'h0000, 8'd8},
    '{16'h0019, 32'h40, 32'h60, 32'h5C, 8'h00, 16'h0000, 16'h0000, 8'd6},
    '{16'h0007, 32'h00, 32'h100, 32'h05, 8'h00, 16'h1111, 16'h2222, 8'd3},
    '{16'h0000, 32'h80, 32'hF5, 32'h81, 8'h0F, 16'h7000, 16'h7000, 8'd4},
    '{16'h0000, 32'h10, 32'h2F, 32'h2D, 8'h42, 16'hFF00, 16'h0010, 8'd4}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r, d;
    logic ex;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) % 256);
    for (int i = 0; i < NCOEF; i++) begin
      coef[i] = i * 613 - 4000;
      coef_flat[i*CW +: CW] = 16'(coef[i]);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rdreg(4'(i), r);
      chk("R1 reset register", {16'd0, r}, 32'd0);
    end
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset done/exc", {30'd0, rd_done, end_exc}, 32'd0);

    // R2 masks and halves
    wr(4'd0, 16'hFFFF); wr(4'd1, 16'hABCD);
    rdreg(4'd0, r); chk("R2 start high mask", {16'd0, r}, 32'h3FFF);
    rdreg(4'd1, r); chk("R2 start low", {16'd0, r}, 32'hABCD);
    wr(4'd2, 16'hC123); rdreg(4'd2, r); chk("R2 end high mask", {16'd0, r}, 32'h0123);
    wr(4'd4, 16'hFFFF); rdreg(4'd4, r); chk("R2 current high mask", {16'd0, r}, 32'hBFFF);
    wr(4'd9, 16'h00FF); rdreg(4'd9, r); chk("R2 predictor mask", {16'd0, r}, 32'h007F);
    wr(4'd6, 16'h1234); rdreg(4'd6, r); chk("R2 format full width", {16'd0, r}, 32'h1234);

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      configure(VECS[v].fmt, VECS[v].st, VECS[v].en, VECS[v].cu,
                VECS[v].ps, VECS[v].y1, VECS[v].y2);
      for (int n = 0; n < int'(VECS[v].n); n++) read_and_compare();
    end

    // R10: stopped after last vector; writing history 2 resumes
    chk("R10 model stopped", {31'd0, m_stop}, 32'd1);
    wr(4'd8, 16'h0040);
    m_y2 = 64; m_stop = 1'b0;
    read_and_compare();
    chk("R10 resumed not stopped", {31'd0, m_stop}, 32'd0);

    // R12 writes ignored while busy, R13 hold with slow memory
    configure(16'h0019, 32'h40, 32'h80, 32'h44, 8'h00, 16'h0, 16'h0);
    lat = 3;
    hold_err = 0;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 16'h1234;
    @(negedge clk); reg_we = 1'b0;
    while (!rd_done) @(negedge clk);
    chk("R3 slow pcm8 sample", {16'd0, rd_data}, {16'd0, mem[8'h44], 8'h00});
    @(negedge clk);
    rdreg(4'd1, r); chk("R12 start unchanged while busy", {16'd0, r}, 32'h0040);
    chk("R13 request held until ack", hold_err, 0);
    rdreg(4'd5, r); chk("R3 pcm8 advance by one", {16'd0, r}, 32'h0045);
    lat = 0;
    do_read(d, ex);
    chk("R3 next pcm8 sample", {16'd0, d}, {16'd0, mem[8'h45], 8'h00});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule